// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a watchdog timer attached to a simple 32-bit register bus. The input clock is first divided by a programmable 8-bit prescaler and then by one of four fixed ratios. Each divided tick decrements a live down-counter. When the counter is already at zero on a tick, it reloads itself from a separate reload register and signals expiry.

Expiry always sets a sticky interrupt flag. The interrupt pin shows that flag only while interrupt enable is set. If reset enable is set, expiry also starts a system reset pulse of fixed length. Software keeps the system alive by rewriting the live count before it runs out.

Every bus access completes in the cycle it is presented. There is no back-pressure and no handshake: a write is taken on the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0x8039 (prescaler 0x80, divide select 3, timer enable 1, reset enable 1, interrupt enable 0). The reload and count registers both read 0x8000, and `wd_irq` and `wd_rst` are low.
- R2: Word offset 0x00 is control, 0x04 is reload, 0x08 is the live count and 0x0C is interrupt clear. Control bits are: 0 reset enable, 2 interrupt enable, 4:3 divide select, 5 timer enable, 15:8 prescaler P. Unused control bits read 0. Write data above bit 15 is ignored for reload and count. Offset 0x0C reads 0.
- R3: With the timer enabled after being stopped, ticks fall on every (P+1)·D-th enabled clock edge, where D is 16, 32, 64 or 128 for divide select 0 to 3. Starting from count N, expiry happens on edge (N+1)·(P+1)·D. On that edge the count becomes the reload value and the interrupt flag rises.
- R4: While timer enable is 0, the live count keeps its value. The divider chain restarts from zero when the timer is enabled again.
- R5: A write to the count register loads the counter at once and takes priority over a tick in the same cycle. It does not disturb the divider phase, so it postpones expiry.
- R6: The interrupt flag is sticky. `wd_irq` equals the flag AND interrupt enable. Writing data with bit 0 set to offset 0x0C clears the flag; writing with bit 0 clear has no effect. If expiry and a clear happen in the same cycle, expiry wins.
- R7: When reset enable is 1, expiry drives `wd_rst` high from the expiry edge for exactly RST_PULSE cycles. When reset enable is 0, expiry leaves `wd_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_irq | output | 1 | Watchdog interrupt (flag gated by enable) |
| wd_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with its default 16-bit counter and 8-bit prescaler, but with RST_PULSE set to 8 so that the whole reset pulse fits in a short window. It sweeps prescaler values 0 to 2 over all four divide selections and three starting counts. This keeps every expiry within about a thousand cycles, so the bench can compare each expiry edge, the zero count just before it and the reloaded count just after it against the product (N+1)(P+1)D computed in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W     = 8;
  localparam int DSEL_W    = 2;
  localparam int NSEL      = 1 << DSEL_W;
  localparam int BASE_LOG2 = 4;                    // smallest divide is 16
  localparam int DIV_W     = BASE_LOG2 + NSEL - 1; // covers up to /128

  // word indices (byte offset >> 2)
  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_RELOAD = 2'd1;
  localparam logic [1:0] IDX_COUNT  = 2'd2;
  localparam logic [1:0] IDX_CLEAR  = 2'd3;

  // control bit positions
  localparam int B_RSTEN = 0;
  localparam int B_IRQEN = 2;
  localparam int B_DSEL  = 3;
  localparam int B_RUN   = 5;
  localparam int B_PRE   = 8;

  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic              run;
    logic [DSEL_W-1:0] dsel;
    logic              irq_en;
    logic              rst_en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output wd_ctrl_t          ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              irq_clr,
  output logic [DATA_W-1:0] rdata
);
  logic [1:0] idx;
  assign idx       = addr[3:2];
  assign cnt_load  = wr && (idx == IDX_COUNT);
  assign cnt_wdata = wdata[CNT_W-1:0];
  assign irq_clr   = wr && (idx == IDX_CLEAR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.pre    <= PRE_W'(8'h80);
      ctrl.run    <= 1'b1;
      ctrl.dsel   <= DSEL_W'(NSEL - 1);
      ctrl.irq_en <= 1'b0;
      ctrl.rst_en <= 1'b1;
      reload      <= CNT_RST;
    end else if (wr) begin
      if (idx == IDX_CTRL) begin
        ctrl.pre    <= wdata[B_PRE +: PRE_W];
        ctrl.run    <= wdata[B_RUN];
        ctrl.dsel   <= wdata[B_DSEL +: DSEL_W];
        ctrl.irq_en <= wdata[B_IRQEN];
        ctrl.rst_en <= wdata[B_RSTEN];
      end
      if (idx == IDX_RELOAD) reload <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_CTRL: begin
        rdata[B_PRE +: PRE_W]   = ctrl.pre;
        rdata[B_RUN]            = ctrl.run;
        rdata[B_DSEL +: DSEL_W] = ctrl.dsel;
        rdata[B_IRQEN]          = ctrl.irq_en;
        rdata[B_RSTEN]          = ctrl.rst_en;
      end
      IDX_RELOAD: rdata[CNT_W-1:0] = reload;
      IDX_COUNT:  rdata[CNT_W-1:0] = cnt_val;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] tops [NSEL];
  logic [DIV_W-1:0] div_top;
  logic             pre_hit;

  for (genvar g = 0; g < NSEL; g++) begin : g_top
    assign tops[g] = DIV_W'((1 << (BASE_LOG2 + g)) - 1);
  end

  assign div_top = tops[dsel];
  assign pre_hit = run && (pre_cnt == pre);
  assign tick    = pre_hit && (div_cnt == div_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= (div_cnt >= div_top) ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= CNT_RST;
    else if (load)   cnt <= load_val;
    else if (expire) cnt <= reload;
    else if (tick)   cnt <= cnt - 1'b1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> (cnt == $past(cnt)));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == '0) |=> (cnt == $past(reload)));
  assert_load_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm #(
  parameter int RST_PULSE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic irq_clr,
  output logic irq,
  output logic rst_out
);
  localparam int PW = $clog2(RST_PULSE + 1);
  logic          flag;
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (expire)  flag <= 1'b1;
    else if (irq_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_cnt <= '0;
    else if (expire && rst_en)  pulse_cnt <= PW'(RST_PULSE);
    else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign irq     = flag && irq_en;
  assign rst_out = (pulse_cnt != '0);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !expire) |=> !flag);
  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_en) |=> rst_out);
  always_comb begin
    assert_pulse_len_R7: assert (!rst_n || pulse_cnt <= PW'(RST_PULSE));
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 128,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst
);
  wd_ctrl_t         ctrl;
  logic [CNT_W-1:0] reload, cnt, cnt_wdata;
  logic             cnt_load, irq_clr, tick, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cnt_val(cnt), .ctrl(ctrl), .reload(reload), .cnt_load(cnt_load),
    .cnt_wdata(cnt_wdata), .irq_clr(irq_clr), .rdata(bus_rdata)
  );

  wdog_tickgen u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .pre(ctrl.pre),
    .dsel(ctrl.dsel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load), .load_val(cnt_wdata),
    .reload(reload), .cnt(cnt), .expire(expire)
  );

  wdog_alarm #(.RST_PULSE(RST_PULSE)) u_alarm (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(ctrl.irq_en),
    .rst_en(ctrl.rst_en), .irq_clr(irq_clr), .irq(wd_irq), .rst_out(wd_rst)
  );

  assert_stopped_no_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !expire);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int PULSE = 8;
  localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CNT = 4'h8, A_CLR = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_irq, wd_rst;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  wdog_timer #(.RST_PULSE(PULSE)) u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq), .wd_rst(wd_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called one time unit after a rising edge; returns one unit after that edge's next
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit ie, input bit re,
                                      input int sel, input int p);
    return (32'(p) << 8) | (32'(run) << 5) | (32'(sel) << 3) | (32'(ie) << 2) | 32'(re);
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset values
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h8039);
    rd(A_REL, v);  chk("R1 reload", v, 32'h8000);
    rd(A_CNT, v);  chk("R1 count", v, 32'h8000);
    chk("R1 irq", 32'(wd_irq), 0);
    chk("R1 rst", 32'(wd_rst), 0);
    // R2 readback
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 unused ctrl bits", v, 32'h0000_FF3D);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl zero", v, 32'h0);
    wr(A_REL, 32'hABCD_1234);
    rd(A_REL, v); chk("R2 reload upper ignored", v, 32'h1234);
    wr(A_CNT, 32'h5555_0777);
    rd(A_CNT, v); chk("R2 count upper ignored", v, 32'h0777);
    rd(A_CLR, v); chk("R2 clear reads zero", v, 32'h0);

    // R3 sweep of prescaler, divide select and start count
    for (int p = 0; p < 3; p++)
      for (int sel = 0; sel < 4; sel++)
        for (int n = 0; n < 3; n++) begin
          int t;
          logic [31:0] rl;
          rl = 32'h100 + 32'(p * 16 + sel * 4 + n);
          t = (n + 1) * (p + 1) * (16 << sel);
          wr(A_CTRL, 0);
          wr(A_CLR, 1);
          wr(A_REL, rl);
          wr(A_CNT, 32'(n));
          wr(A_CTRL, ctl(1, 1, 0, sel, p));
          bus_addr = A_CNT;
          repeat (t - 1) @(posedge clk);
          #1;
          chk("R3 no expiry before period", 32'(wd_irq), 0);
          rd(A_CNT, v); chk("R3 count zero before expiry", v, 0);
          @(posedge clk); #1;
          chk("R3 expiry at period", 32'(wd_irq), 1);
          rd(A_CNT, v); chk("R3 reloaded", v, rl);
          chk("R7 no reset when disabled", 32'(wd_rst), 0);
        end

    // R4 stop freezes the count
    wr(A_CTRL, 0); wr(A_CLR, 1); wr(A_REL, 32'h1000);
    wr(A_CNT, 32'h50);
    wr(A_CTRL, ctl(1, 0, 0, 0, 0));
    repeat (100) @(posedge clk); #1;
    wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R4 count at stop", v, 32'h4A);
    repeat (300) @(posedge clk); #1;
    rd(A_CNT, v2); chk("R4 count frozen", v2, 32'h4A);

    // R5 keep-alive postpones expiry
    wr(A_CTRL, 0); wr(A_CLR, 1);
    wr(A_CNT, 2);
    wr(A_CTRL, ctl(1, 1, 0, 0, 0));
    repeat (40) @(posedge clk); #1;
    wr(A_CNT, 2);
    bus_addr = A_CNT;
    repeat (38) @(posedge clk); #1;
    chk("R5 no expiry after keep-alive", 32'(wd_irq), 0);
    rd(A_CNT, v); chk("R5 count after keep-alive", v, 0);
    @(posedge clk); #1;
    chk("R5 expiry postponed", 32'(wd_irq), 1);

    // R6 masking, stickiness and clear
    wr(A_CTRL, 0); wr(A_CLR, 1);
    wr(A_CNT, 0);
    wr(A_CTRL, ctl(1, 0, 0, 0, 0));
    repeat (20) @(posedge clk); #1;
    chk("R6 masked irq", 32'(wd_irq), 0);
    wr(A_CTRL, ctl(0, 1, 0, 0, 0));
    chk("R6 sticky flag shows on enable", 32'(wd_irq), 1);
    wr(A_CLR, 32'hFFFF_FFFE);
    chk("R6 clear with bit0 low ignored", 32'(wd_irq), 1);
    wr(A_CLR, 1);
    chk("R6 cleared", 32'(wd_irq), 0);

    // R7 reset pulse length
    wr(A_CTRL, 0); wr(A_REL, 32'h1000);
    wr(A_CNT, 0);
    wr(A_CTRL, ctl(1, 0, 1, 0, 0));
    repeat (15) @(posedge clk); #1;
    chk("R7 no pulse before expiry", 32'(wd_rst), 0);
    @(posedge clk); #1;
    chk("R7 pulse starts", 32'(wd_rst), 1);
    repeat (PULSE - 1) @(posedge clk); #1;
    chk("R7 pulse last cycle", 32'(wd_rst), 1);
    @(posedge clk); #1;
    chk("R7 pulse ended", 32'(wd_rst), 0);
    wr(A_CTRL, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule